// File: doc/BRIEF.md
# ADC Level Statistics Accumulator

This block measures signal power on eight digitizer inputs at the same time. Each input carries 8-bit two's-complement samples. A single strobe marks the cycles on which all eight samples are valid. After the host writes the control strobe, the block adds up a fixed block of 65536 valid samples per input. It keeps two totals for each input: the signed sum and the unsigned sum of squares. It then commits both totals for every input into a small result memory in one cycle and raises a done flag.

The host reads the results through a combinational read port. Input `i` keeps its signed sum at word `2i` and its sum of squares at word `2i+1`. The host derives the mean, the variance and the RMS from these two numbers in software. Until the next measurement completes, the memory keeps the previous results. A new control write clears the accumulators and starts again, including when it arrives during a measurement.

Top module: `adc_level_stats`

## Requirements
- R1: While reset is low, and right after reset, `done` is 0 and all 16 result words read 0.
- R2: Until the first `ctl_wr`, nothing is accumulated: valid samples leave every result word at 0 and keep `done` at 0.
- R3: Word `2i` holds the two's-complement sum of input `i`'s samples in bits 23:0, with bits 31:24 at zero. Input `i` occupies `smp_bus[8i+7:8i]`.
- R4: Word `2i+1` holds the 32-bit unsigned sum of the squares of input `i`'s samples.
- R5: During a measurement, a sample is counted only on a cycle where `smp_vld` is 1 and `ctl_wr` is 0. Idle cycles change nothing, and after completion valid samples are ignored.
- R6: All 16 words update together on the clock edge that accepts the 65536th valid sample. Before that edge, reads return the previous results unchanged.
- R7: `done` goes to 1 on the commit edge. It stays at 1 until a `ctl_wr`, and it is 0 from the edge that takes that write.
- R8: A `ctl_wr` during a measurement restarts it. The count and the totals clear, and the samples presented together with `ctl_wr` are not counted.
- R9: Full-scale inputs produce no overflow. A constant -128 gives sum 0x00800000 and squares 0x40000000. A constant +127 gives 0x007F0000 and 0x3F010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_bus | input | 64 | Eight packed signed 8-bit samples; input i at bits 8i+7:8i |
| smp_vld | input | 1 | All samples valid this cycle |
| ctl_wr | input | 1 | Control write; starts or restarts a measurement |
| rd_addr | input | 4 | Result word address |
| rd_data | output | 32 | Result word at rd_addr (combinational) |
| done | output | 1 | Results of the last measurement committed |

## Verification
The `done` flag and the result words both change on the clock edge that takes the accepting sample or the control write. A read of a word is combinational, so its value is due in the same cycle the address is applied. The bench model updates on the same rising edge as the design. It compares `done` and the word at the current scan address on every falling edge. Directed reads of the full-scale words change the address on a falling edge and sample 2 ns later, before the next rising edge.

// File: rtl/adc_level_stats.sv
module adc_level_stats #(
  parameter int NUM_IN = 8,
  parameter int SW     = 8,
  parameter int LOG_N  = 16,
  parameter int SUM_W  = 24,
  parameter int SQ_W   = 32,
  parameter int ADDR_W = $clog2(2*NUM_IN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IN*SW-1:0] smp_bus,
  input  logic                 smp_vld,
  input  logic                 ctl_wr,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [SQ_W-1:0]      rd_data,
  output logic                 done
);
  localparam int NWORD = 2*NUM_IN;
  localparam int PW    = 2*SW;

  logic             busy;
  logic [LOG_N-1:0] cnt;
  logic [SUM_W-1:0] sum_acc [NUM_IN];
  logic [SQ_W-1:0]  sq_acc  [NUM_IN];
  logic [SUM_W-1:0] sum_nx  [NUM_IN];
  logic [SQ_W-1:0]  sq_nx   [NUM_IN];
  logic [SQ_W-1:0]  res_mem [NWORD];

  wire take   = busy & smp_vld & ~ctl_wr;
  wire commit = take & (&cnt);

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      logic signed [SW-1:0] s;
      logic signed [PW-1:0] p;
      s = smp_bus[i*SW +: SW];
      p = s * s;
      sum_nx[i] = sum_acc[i] + {{(SUM_W-SW){s[SW-1]}}, s};
      sq_nx[i]  = sq_acc[i] + {{(SQ_W-PW){1'b0}}, p};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      for (int i = 0; i < NUM_IN; i++) begin
        sum_acc[i] <= '0;
        sq_acc[i]  <= '0;
      end
      for (int w = 0; w < NWORD; w++) res_mem[w] <= '0;
    end else if (ctl_wr) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= '0;
      for (int i = 0; i < NUM_IN; i++) begin
        sum_acc[i] <= '0;
        sq_acc[i]  <= '0;
      end
    end else if (take) begin
      cnt <= cnt + 1'b1;
      for (int i = 0; i < NUM_IN; i++) begin
        sum_acc[i] <= sum_nx[i];
        sq_acc[i]  <= sq_nx[i];
      end
      if (commit) begin
        busy <= 1'b0;
        done <= 1'b1;
        for (int i = 0; i < NUM_IN; i++) begin
          res_mem[2*i]   <= {{(SQ_W-SUM_W){1'b0}}, sum_nx[i]};
          res_mem[2*i+1] <= sq_nx[i];
        end
      end
    end
  end

  assign rd_data = res_mem[rd_addr];

endmodule

// File: rtl/adc_level_stats_chk.sv
module adc_level_stats_chk #(
  parameter int LOG_N  = 16,
  parameter int SQ_W   = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic              ctl_wr,
  input logic              done,
  input logic              busy,
  input logic [LOG_N-1:0]  cnt,
  input logic              commit,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [SQ_W-1:0]   rd_data
);
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !done);

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ctl_wr |=> done);

  assert_done_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done && !busy);

  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));

  assert_idle_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld && !ctl_wr |=> $stable(cnt));

  assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ctl_wr |=> !busy);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> busy && cnt == '0);
endmodule

bind adc_level_stats adc_level_stats_chk #(
  .LOG_N(LOG_N), .SQ_W(SQ_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .ctl_wr(ctl_wr),
  .done(done), .busy(busy), .cnt(cnt), .commit(commit),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_adc_level_stats.sv
`timescale 1ns/1ps
module test_adc_level_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] smp_bus = '0;
  logic        smp_vld = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done;

  adc_level_stats i_adc_level_stats (
    .clk(clk), .rst_n(rst_n), .smp_bus(smp_bus), .smp_vld(smp_vld),
    .ctl_wr(ctl_wr), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  always #10 clk = ~clk;

  int     nvec = 0, nerr = 0, cyc = 0;
  bit     scan_en = 1'b1;
  string  phase = "R1";

  longint     m_sum [8];
  longint     m_sq  [8];
  logic [31:0] m_mem [16];
  bit         m_busy, m_done;
  int         m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      for (int i = 0; i < 8; i++) begin m_sum[i] = 0; m_sq[i] = 0; end
      for (int w = 0; w < 16; w++) m_mem[w] = 0;
    end else if (ctl_wr) begin
      m_busy = 1; m_done = 0; m_cnt = 0;
      for (int i = 0; i < 8; i++) begin m_sum[i] = 0; m_sq[i] = 0; end
    end else if (m_busy && smp_vld) begin
      for (int i = 0; i < 8; i++) begin
        int v;
        v = $signed(smp_bus[i*8 +: 8]);
        m_sum[i] += v;
        m_sq[i]  += v * v;
      end
      m_cnt++;
      if (m_cnt == 65536) begin
        m_busy = 0; m_done = 1;
        for (int i = 0; i < 8; i++) begin
          m_mem[2*i]   = 32'(m_sum[i]) & 32'h00FF_FFFF;
          m_mem[2*i+1] = 32'(m_sq[i]);
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nerr++;
      $display("FAIL R6 watchdog: actual done=%0b expected completion", done);
      summary();
    end
    nvec++;
    if (done !== m_done) begin
      nerr++;
      $display("FAIL R7 (%s) done: actual %0b expected %0b", phase, done, m_done);
    end
    nvec++;
    if (rd_data !== m_mem[rd_addr]) begin
      nerr++;
      if (rd_addr[0] == 1'b0)
        $display("FAIL R3 (%s) addr %0d: actual %h expected %h", phase, rd_addr, rd_data, m_mem[rd_addr]);
      else
        $display("FAIL R4 (%s) addr %0d: actual %h expected %h", phase, rd_addr, rd_data, m_mem[rd_addr]);
    end
    if (scan_en) rd_addr <= rd_addr + 4'd1;
  end

  function automatic logic [63:0] gen(bit full_scale);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (full_scale) begin
      v[7:0] = 8'h80; v[15:8] = 8'h7F; v[23:16] = 8'h00;
    end
    return v;
  endfunction

  task automatic cycles(int n, bit gaps, bit full_scale);
    repeat (n) begin
      @(negedge clk);
      ctl_wr  <= 1'b0;
      smp_vld <= gaps ? (($urandom % 8) != 0) : 1'b1;
      smp_bus <= gen(full_scale);
    end
  endtask

  task automatic start();
    @(negedge clk);
    ctl_wr  <= 1'b1;
    smp_vld <= 1'b1;
    smp_bus <= gen(1'b0);
  endtask

  task automatic until_done(bit gaps, bit full_scale);
    while (!m_done) cycles(1, gaps, full_scale);
  endtask

  task automatic direct_read(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_addr <= a;
    #2;
    nvec++;
    if (rd_data !== exp) begin
      nerr++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  initial begin
    phase = "R1";
    cycles(5, 1'b0, 1'b0);
    @(negedge clk) rst_n <= 1'b1;
    cycles(20, 1'b0, 1'b0);
    phase = "R2";
    cycles(300, 1'b1, 1'b0);
    phase = "R9 full scale";
    start();
    until_done(1'b0, 1'b1);
    phase = "R5 after done";
    cycles(40, 1'b0, 1'b0);
    scan_en = 1'b0;
    direct_read(4'd0, 32'h0080_0000, "R9 sum -128");
    direct_read(4'd1, 32'h4000_0000, "R9 sq -128");
    direct_read(4'd2, 32'h007F_0000, "R9 sum +127");
    direct_read(4'd3, 32'h3F01_0000, "R9 sq +127");
    direct_read(4'd4, 32'h0000_0000, "R9 sum zero");
    direct_read(4'd5, 32'h0000_0000, "R9 sq zero");
    scan_en = 1'b1;
    phase = "R8 restart";
    start();
    cycles(500, 1'b1, 1'b0);
    start();
    start();
    phase = "R6 gapped";
    until_done(1'b1, 1'b0);
    cycles(30, 1'b1, 1'b0);
    phase = "R7 clear";
    start();
    cycles(30, 1'b1, 1'b0);
    summary();
  end
endmodule